// File: doc/BRIEF.md
# Slow-tick prescaler and control register

This block sits in front of a low-power counter. It holds one byte of control state: a division-ratio code, a clock-source select and a compare-enable flag. From that state it produces a divided count-enable pulse for the counter that follows it. Both candidate clock sources arrive as single-cycle enable strobes in the bus clock domain. The block picks one of them, counts its strobes, and emits one bus-cycle pulse for every N strobes, where N is a power of two from 2 to 32.

Software reads and writes the register over a byte-wide port. A write takes effect only while the protection-release input is high. The stop input gates the counting clock. While stop is low, the division and source fields are frozen, so the ratio cannot change under a running counter. The compare-enable bit stays writable at all times. A prohibited division code is never stored. Instead it raises a one-cycle error flag.

Top module: `tick_div_ctrl`

## Requirements
- R1: The read port returns the division code on bits 2:0, the source select on bit 4 and the compare enable on bit 6; `cmp_en_o` equals bit 6.
- R2: Division codes 1, 2, 3, 4 and 5 select ratios of 2, 4, 8, 16 and 32 (ratio = 2^code). Codes 0, 6 and 7 are never stored, and the division field keeps its previous value.
- R3: Bits 7, 5 and 3 always read as 0, whatever value is written to them.
- R4: After reset the read value is 8'h01, and `cmp_en_o`, `cnt_en_o` and `cfg_err_o` are 0.
- R5: A write with `prot_off_i` = 0 changes no field.
- R6: A write with `stop_i` = 0 leaves the division and source fields unchanged. It still updates the compare-enable bit.
- R7: A write with `prot_off_i` = 1, `stop_i` = 1 and a prohibited division code raises `cfg_err_o` for exactly the one cycle after the write edge. The same write still updates the source and compare fields.
- R8: With `stop_i` = 0, `cnt_en_o` is high for one cycle, in the cycle after every N-th selected strobe is sampled, where N is the ratio of R2.
- R9: Source select 0 counts `src_stb_i[0]` and source select 1 counts `src_stb_i[1]`. Strobes on the unselected source have no effect.
- R10: While `stop_i` = 1 the divider count is held at zero and `cnt_en_o` stays 0. After `stop_i` returns to 0, the next pulse comes after a full N selected strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_i | input | 1 | Register write strobe |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Register read value |
| prot_off_i | input | 1 | 1 lifts write protection |
| stop_i | input | 1 | 1 stops the counting clock |
| src_stb_i | input | 2 | Enable strobes of the two clock sources |
| cnt_en_o | output | 1 | Divided count-enable pulse |
| cmp_en_o | output | 1 | Compare-match enable flag |
| cfg_err_o | output | 1 | One-cycle prohibited-code flag |

## Verification
The assertions assume that each source strobe is high for a single bus cycle. They also assume that strobes on the selected source are at least four bus cycles apart, which matches the required ratio between the bus clock and the source clock. The bench drives each counted strobe for one cycle and then leaves at least three idle cycles before the next one. An unselected-source strobe is placed only inside those idle cycles, so it never overlaps a counted strobe. Writes and changes to `stop_i` are applied on the falling clock edge, so every register field sees a clean, single-edge update.

// File: rtl/tdc_pkg.sv
package tdc_pkg;
  localparam int DIV_W    = 3;
  localparam int MAX_CODE = 5;
  localparam int SRC_BIT  = 4;
  localparam int CMP_BIT  = 6;
  localparam int N_SRC    = 2;
  localparam int SRC_W    = (N_SRC > 1) ? $clog2(N_SRC) : 1;
  localparam int CNT_W    = MAX_CODE;
  localparam logic [DIV_W-1:0] DIV_RST = 3'd1;

  function automatic logic div_ok(input logic [DIV_W-1:0] c);
    return (c != '0) && (int'(c) <= MAX_CODE);
  endfunction
endpackage

// File: rtl/tdc_cfg.sv
module tdc_cfg
  import tdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  input  logic             prot_off_i,
  input  logic             stop_i,
  output logic [DIV_W-1:0] div_o,
  output logic [SRC_W-1:0] src_o,
  output logic             cmp_o,
  output logic             err_o
);
  logic             wr_ok;
  logic [DIV_W-1:0] wdiv;
  logic             unused_w;

  assign wr_ok    = wr_i && prot_off_i;
  assign wdiv     = wdata_i[DIV_W-1:0];
  assign unused_w = ^{wdata_i[7], wdata_i[5], wdata_i[3]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      div_o <= DIV_RST;
      src_o <= '0;
      cmp_o <= 1'b0;
      err_o <= 1'b0;
    end else begin
      err_o <= 1'b0;
      if (wr_ok) begin
        cmp_o <= wdata_i[CMP_BIT];
        // ratio/source frozen while running
        if (stop_i) begin
          src_o <= wdata_i[SRC_BIT +: SRC_W];
          if (div_ok(wdiv)) div_o <= wdiv;
          else              err_o <= 1'b1;
        end
      end
    end
  end

  AST_DIV_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    div_ok(div_o)); // R2
  AST_NO_PROT_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !prot_off_i |=> $stable(div_o) && $stable(src_o) && $stable(cmp_o)); // R5
  AST_RUN_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stop_i |=> $stable(div_o) && $stable(src_o)); // R6
  AST_ERR_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> $past(wr_i && prot_off_i && stop_i && !div_ok(wdata_i[DIV_W-1:0]))); // R7
endmodule

// File: rtl/tdc_src.sv
module tdc_src
  import tdc_pkg::*;
(
  input  logic [N_SRC-1:0] stb_i,
  input  logic [SRC_W-1:0] sel_i,
  output logic             stb_o
);
  logic [N_SRC-1:0] hit;

  for (genvar i = 0; i < N_SRC; i++) begin : g_src
    assign hit[i] = stb_i[i] && (int'(sel_i) == i);
  end

  assign stb_o = |hit;
endmodule

// File: rtl/tdc_div.sv
module tdc_div
  import tdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_i,
  input  logic             stb_i,
  input  logic [DIV_W-1:0] code_i,
  output logic             pulse_o
);
  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] term;
  logic             pulse_q;

  assign term = CNT_W'((32'd1 << code_i) - 32'd1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else if (stop_i) begin
      cnt_q   <= '0;
      pulse_q <= 1'b0;
    end else begin
      pulse_q <= 1'b0;
      if (stb_i) begin
        if (cnt_q >= term) begin
          cnt_q   <= '0;
          pulse_q <= 1'b1;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end

  assign pulse_o = pulse_q && !stop_i;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= term); // R8
  AST_STOP_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |=> (cnt_q == '0)); // R10
  AST_STOP_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_i |-> !pulse_o); // R10
endmodule

// File: rtl/tick_div_ctrl.sv
module tick_div_ctrl
  import tdc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [7:0]       wdata_i,
  output logic [7:0]       rdata_o,
  input  logic             prot_off_i,
  input  logic             stop_i,
  input  logic [N_SRC-1:0] src_stb_i,
  output logic             cnt_en_o,
  output logic             cmp_en_o,
  output logic             cfg_err_o
);
  logic [DIV_W-1:0] div_q;
  logic [SRC_W-1:0] src_q;
  logic             cmp_q;
  logic             sel_stb;

  tdc_cfg u_cfg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (wr_i),
    .wdata_i    (wdata_i),
    .prot_off_i (prot_off_i),
    .stop_i     (stop_i),
    .div_o      (div_q),
    .src_o      (src_q),
    .cmp_o      (cmp_q),
    .err_o      (cfg_err_o)
  );

  tdc_src u_src (
    .stb_i (src_stb_i),
    .sel_i (src_q),
    .stb_o (sel_stb)
  );

  tdc_div u_div (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .stop_i  (stop_i),
    .stb_i   (sel_stb),
    .code_i  (div_q),
    .pulse_o (cnt_en_o)
  );

  always_comb begin
    rdata_o                        = '0;
    rdata_o[DIV_W-1:0]             = div_q;
    rdata_o[SRC_BIT +: SRC_W]      = src_q;
    rdata_o[CMP_BIT]               = cmp_q;
  end

  assign cmp_en_o = cmp_q;

  AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_en_o |=> !cnt_en_o); // R8
  AST_NO_STB_NO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_stb |=> !cnt_en_o); // R9
endmodule

// File: tb/sim_tick_div_ctrl.sv
module sim_tick_div_ctrl;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr = 1'b0;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic       prot = 1'b0;
  logic       stop = 1'b1;
  logic [1:0] stb = '0;
  logic       cnt_en, cmp_en, cfg_err;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tick_div_ctrl u0 (
    .clk_i(clk), .rst_ni(rst_n), .wr_i(wr), .wdata_i(wdata), .rdata_o(rdata),
    .prot_off_i(prot), .stop_i(stop), .src_stb_i(stb),
    .cnt_en_o(cnt_en), .cmp_en_o(cmp_en), .cfg_err_o(cfg_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s act %0d exp %0d", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic [7:0] d);
    @(negedge clk); wr = 1'b1; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic pulse_src(input int s);
    @(negedge clk); stb[s] = 1'b1;
    @(negedge clk); stb = '0;
  endtask

  task automatic idle(input int alt);
    @(negedge clk);
    if (alt >= 0) begin
      stb[alt] = 1'b1;
      @(negedge clk); stb = '0;
      chk(cnt_en == 1'b0, "R9 unselected strobe", cnt_en, 0);
    end else @(negedge clk);
    @(negedge clk);
  endtask

  function automatic bit legal(input int c);
    return c >= 1 && c <= 5;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog act 0 exp 1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(rdata == 8'h01, "R4 reset value", rdata, 8'h01);
    chk(!cmp_en && !cnt_en && !cfg_err, "R4 reset outputs",
        {cmp_en, cnt_en, cfg_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rdata == 8'h01, "R4 value after release", rdata, 8'h01);

    // protection
    stop = 1'b1; prot = 1'b0;
    wr_reg(8'h53);
    chk(rdata == 8'h01, "R5 protected write", rdata, 8'h01);
    chk(cfg_err == 1'b0, "R5 no error when protected", cfg_err, 0);
    prot = 1'b1;

    // sweep code x source x compare
    for (int code = 0; code < 8; code++) begin
      for (int s = 0; s < 2; s++) begin
        for (int c = 0; c < 2; c++) begin
          logic [7:0] d;
          int ediv, n;
          stop = 1'b1;
          wr_reg(8'h02);
          d = {1'b1, 1'(c), 1'b1, 1'(s), 1'b1, 3'(code)};
          wr_reg(d);
          ediv = legal(code) ? code : 2;
          chk(rdata == {1'b0, 1'(c), 1'b0, 1'(s), 1'b0, 3'(ediv)},
              "R1 R2 R3 readback", rdata, {1'b0, 1'(c), 1'b0, 1'(s), 1'b0, 3'(ediv)});
          chk(cmp_en == 1'(c), "R1 compare flag", cmp_en, c);
          chk(cfg_err == !legal(code), "R7 error pulse", cfg_err, !legal(code));
          @(negedge clk);
          chk(cfg_err == 1'b0, "R7 error one cycle", cfg_err, 0);
          // count with the stored ratio
          n = 1 << ediv;
          stop = 1'b0;
          for (int k = 1; k <= 2 * n; k++) begin
            pulse_src(s);
            chk(cnt_en == ((k % n) == 0), "R8 divided pulse", cnt_en, (k % n) == 0);
            @(negedge clk);
            chk(cnt_en == 1'b0, "R8 pulse width", cnt_en, 0);
            idle(1 - s);
          end
        end
      end
    end

    // writes while running: ratio/source frozen, compare writable
    stop = 1'b1;
    wr_reg(8'h03);
    stop = 1'b0;
    wr_reg(8'h51);
    chk(rdata == 8'h43, "R6 running write", rdata, 8'h43);
    chk(cfg_err == 1'b0, "R6 no error when running", cfg_err, 0);
    wr_reg(8'h07);
    chk(rdata == 8'h03 && !cfg_err, "R6 running illegal ignored", rdata, 8'h03);

    // stop holds count at zero, resume from zero (N = 8, source 0)
    for (int k = 0; k < 5; k++) begin pulse_src(0); idle(-1); end
    @(negedge clk); stop = 1'b1;
    for (int k = 0; k < 10; k++) begin
      pulse_src(0);
      chk(cnt_en == 1'b0, "R10 no pulse while stopped", cnt_en, 0);
      idle(-1);
    end
    @(negedge clk); stop = 1'b0;
    for (int k = 1; k <= 8; k++) begin
      pulse_src(0);
      chk(cnt_en == (k == 8), "R10 resume from zero", cnt_en, k == 8);
      idle(-1);
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule